// File: doc/BRIEF.md
# Two-Word Packet Header Generator

In the low-bandwidth path, every packet of time-domain samples begins with a header of two 64-bit words, and this block produces it. A one-cycle start strobe captures a 60-bit packet counter and a 4-bit status code. The block then drives the two words out on a valid/ready stream and raises a last flag on the second word. Both words use one layout: the counter sits in the upper bits and the status in the low nibble. The second word repeats the status and carries the counter plus one.

A build-time option removes the external counter input from use. In that variant an internal register supplies the counter value. It starts at zero after reset and grows by two for each header, so the counters in successive headers never overlap.

Top module: `pkt_header_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, `hdr_valid_o` is 0.
- R2: A `start_i` pulse while idle causes the next cycle to show `hdr_valid_o`=1, `hdr_last_o`=0, and `hdr_data_o` with bits 63:4 equal to the counter sampled at the start and bits 3:0 equal to the status sampled at the start.
- R3: After the first word is accepted (valid and ready both high), the next cycle shows the second word. Its bits 3:0 equal the first word's bits 3:0, its bits 63:4 equal the first word's bits 63:4 plus one, and `hdr_last_o`=1.
- R4: The increment in the second word wraps modulo 2^60, so a counter of all ones becomes zero.
- R5: While `hdr_valid_o` is 1 and `hdr_ready_i` is 0, the next cycle keeps `hdr_valid_o`, `hdr_data_o` and `hdr_last_o` unchanged.
- R6: While a header is being sent, `start_i` has no effect, and changes on the counter and status inputs have no effect: the words in progress do not change and no further header follows.
- R7: A header is exactly two words. After the second word is accepted, `hdr_valid_o` is 0 on the next cycle.
- R8: When the internal counter option is set (`USE_INT_CNT`=1), the first header after reset carries counter 0, and each later header carries a counter two greater than the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request one header; acted on only when idle |
| cnt_i | input | 60 | External packet counter, sampled on start |
| status_i | input | 4 | Status code, sampled on start |
| hdr_data_o | output | 64 | Header word: counter in 63:4, status in 3:0 |
| hdr_valid_o | output | 1 | Header word available |
| hdr_last_o | output | 1 | Marks the second and final header word |
| hdr_ready_i | input | 1 | Downstream accepts the current word |

## Verification
Several properties are checked on every cycle: stream stability under backpressure, the word-to-word relation of the counter and status fields (including wrap), a first word without the last flag, and the drop of valid after the last word. Other behaviour needs the bench's scenarios. These are that each word matches the values sampled at start even when the inputs change afterwards, that starts during a header are ignored, that a counter of all ones wraps to zero, and that the internal counter steps by two from zero across headers.

// File: rtl/phg_pkg.sv
// Package: types shared by the packet header generator.
// Assumes: nothing beyond standard SystemVerilog.
package phg_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_t;
endpackage

// File: rtl/phg_capture.sv
// Module: phg_capture
// Holds the counter and status of the header in progress. It loads them on
// load_i and adds one to the counter in place on bump_i. The USE_INT_CNT
// option makes an internal counter the source; it steps by two per load.
// Assumes: load_i and bump_i are never high together.
module phg_capture #(
    parameter int CNT_W       = 60,
    parameter int STAT_W      = 4,
    parameter bit USE_INT_CNT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              bump_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [CNT_W-1:0]  cnt_q_o,
    output logic [STAT_W-1:0] stat_q_o
);
    localparam logic [CNT_W-1:0] STEP_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] STEP_TWO = CNT_W'(2);

    logic [CNT_W-1:0] src_cnt;

    generate
        if (USE_INT_CNT) begin : g_int_cnt
            logic [CNT_W-1:0] int_q;
            // Internal counter: starts at zero, steps by two per header.
            always_ff @(posedge clk) begin
                if (!rst_n)      int_q <= '0;
                else if (load_i) int_q <= int_q + STEP_TWO;
            end
            assign src_cnt = int_q;
        end else begin : g_ext_cnt
            assign src_cnt = cnt_i;
        end
    endgenerate

    // Counter register: load on start, add one for the second word.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q_o <= '0;
        else if (load_i) cnt_q_o <= src_cnt;
        else if (bump_i) cnt_q_o <= cnt_q_o + STEP_ONE;
    end

    // Status register: load on start, hold for both words.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_q_o <= '0;
        else if (load_i) stat_q_o <= status_i;
    end
endmodule

// File: rtl/phg_seq.sv
// Module: phg_seq
// Three-state sequencer that walks idle, first word, second word. It
// accepts start only when idle and advances only on a handshake.
// Assumes: ready may change on any cycle, including while valid is low.
module phg_seq
    import phg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ready_i,
    output logic load_o,
    output logic bump_o,
    output logic valid_o,
    output logic last_o
);
    seq_state_t state_q, state_d;

    // Next-state decode: each move out of a word state needs ready.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (start_i) state_d = SEQ_FIRST;
            SEQ_FIRST:  if (ready_i) state_d = SEQ_SECOND;
            SEQ_SECOND: if (ready_i) state_d = SEQ_IDLE;
            default:                 state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign load_o  = start_i && (state_q == SEQ_IDLE);
    assign bump_o  = ready_i && (state_q == SEQ_FIRST);
    assign valid_o = (state_q != SEQ_IDLE);
    assign last_o  = (state_q == SEQ_SECOND);
endmodule

// File: rtl/pkt_header_gen.sv
// Module: pkt_header_gen (top)
// Produces a two-word packet header on a valid/ready stream. Each word
// carries the counter in its upper bits and the status in its low bits. The
// second word repeats the status and carries the counter plus one.
// Assumes: a start that arrives while a header is in progress is dropped.
module pkt_header_gen #(
    parameter int CNT_W       = 60,
    parameter int STAT_W      = 4,
    parameter bit USE_INT_CNT = 1'b0,
    localparam int WORD_W     = CNT_W + STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [WORD_W-1:0] hdr_data_o,
    output logic              hdr_valid_o,
    output logic              hdr_last_o,
    input  logic              hdr_ready_i
);
    logic              load;
    logic              bump;
    logic [CNT_W-1:0]  cnt_q;
    logic [STAT_W-1:0] stat_q;

    phg_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ready_i (hdr_ready_i),
        .load_o  (load),
        .bump_o  (bump),
        .valid_o (hdr_valid_o),
        .last_o  (hdr_last_o)
    );

    phg_capture #(
        .CNT_W       (CNT_W),
        .STAT_W      (STAT_W),
        .USE_INT_CNT (USE_INT_CNT)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .bump_i   (bump),
        .cnt_i    (cnt_i),
        .status_i (status_i),
        .cnt_q_o  (cnt_q),
        .stat_q_o (stat_q)
    );

    assign hdr_data_o = {cnt_q, stat_q};
endmodule

// File: rtl/pkt_header_gen_chk.sv
// Module: pkt_header_gen_chk
// Checker for the stream-level properties of pkt_header_gen. It is attached
// to every instance through the bind statement at the end of this file.
// Assumes: the top uses its default field split at the port level.
module pkt_header_gen_chk #(
    parameter int CNT_W  = 60,
    parameter int STAT_W = 4,
    localparam int WORD_W = CNT_W + STAT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] hdr_data_o,
    input logic              hdr_valid_o,
    input logic              hdr_last_o,
    input logic              hdr_ready_i
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !hdr_valid_o);

    assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_valid_o) |-> !hdr_last_o);

    assert_second_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_o && hdr_ready_i && !hdr_last_o) |=>
        (hdr_valid_o && hdr_last_o
         && hdr_data_o[STAT_W-1:0] == $past(hdr_data_o[STAT_W-1:0])
         && hdr_data_o[WORD_W-1:STAT_W] ==
            CNT_W'($past(hdr_data_o[WORD_W-1:STAT_W]) + CNT_W'(1))));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_o && !hdr_ready_i) |=>
        (hdr_valid_o && $stable(hdr_data_o) && $stable(hdr_last_o)));

    assert_two_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_o && hdr_ready_i && hdr_last_o) |=> !hdr_valid_o);
endmodule

bind pkt_header_gen pkt_header_gen_chk #(
    .CNT_W  (CNT_W),
    .STAT_W (STAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_data_o  (hdr_data_o),
    .hdr_valid_o (hdr_valid_o),
    .hdr_last_o  (hdr_last_o),
    .hdr_ready_i (hdr_ready_i)
);

// File: tb/pkt_header_gen_test.sv
// Directed bench for pkt_header_gen. Inputs change on the falling edge and
// outputs are sampled there as well. uut reads the external counter;
// uut_int runs on the same stimulus with its internal counter.
module pkt_header_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [59:0] cnt = '0;
    logic [3:0]  status = '0;
    logic        ready = 1'b0;
    logic [63:0] data, data_int;
    logic        valid, valid_int, last, last_int;

    int checks = 0;
    int errors = 0;
    logic [59:0] int_exp = '0;

    always #4 clk = ~clk;

    pkt_header_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cnt_i(cnt),
        .status_i(status), .hdr_data_o(data), .hdr_valid_o(valid),
        .hdr_last_o(last), .hdr_ready_i(ready));

    pkt_header_gen #(.USE_INT_CNT(1'b1)) uut_int (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cnt_i(cnt),
        .status_i(status), .hdr_data_o(data_int), .hdr_valid_o(valid_int),
        .hdr_last_o(last_int), .hdr_ready_i(ready));

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R1: no valid output during or right after reset.
    task automatic test_reset();
        check(valid == 1'b0, "R1 valid in reset", 64'(valid), 64'd0);
        rst_n = 1'b1;
        tick();
        check(valid == 1'b0, "R1 valid after reset", 64'(valid), 64'd0);
        check(valid_int == 1'b0, "R1 valid_int after reset", 64'(valid_int), 64'd0);
    endtask

    // One full header with given stalls. Starts and input changes are
    // applied during transfer (R6), and the internal unit is checked (R8).
    task automatic run_header(input logic [59:0] c, input logic [3:0] s,
                              input int stall0, input int stall1, input string tag);
        logic [63:0] w0, w1;
        w0 = {c, s};
        w1 = {c + 60'd1, s};
        cnt = c; status = s; start = 1'b1; ready = 1'b0;
        tick();
        start = 1'b0;
        cnt = ~c; status = ~s;
        check(valid && !last && data == w0, {"R2 first word ", tag}, data, w0);
        check(valid_int && data_int == {int_exp, s},
              {"R8 int first word ", tag}, data_int, {int_exp, s});
        for (int i = 0; i < stall0; i++) begin
            start = 1'b1;
            tick();
            check(valid && !last && data == w0, {"R5 hold first ", tag}, data, w0);
        end
        start = 1'b1;
        ready = 1'b1;
        tick();
        ready = 1'b0;
        check(valid && last && data == w1, {"R3 second word ", tag}, data, w1);
        check(data_int == {int_exp + 60'd1, s}, {"R8 int second word ", tag},
              data_int, {int_exp + 60'd1, s});
        for (int i = 0; i < stall1; i++) begin
            tick();
            check(valid && last && data == w1, {"R5 hold second ", tag}, data, w1);
        end
        ready = 1'b1;
        tick();
        start = 1'b0;
        ready = 1'b0;
        check(!valid, {"R7 end of header ", tag}, 64'(valid), 64'd0);
        tick();
        check(!valid && !valid_int, {"R6 no restart ", tag}, 64'(valid), 64'd0);
        int_exp = int_exp + 60'd2;
    endtask

    // R4: a counter of all ones wraps to zero in the second word.
    task automatic test_wrap();
        run_header({60{1'b1}}, 4'hA, 0, 0, "wrap R4");
        check(({60{1'b1}} + 60'd1) == 60'd0, "R4 expected wrap", 64'd0, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        run_header(60'h123_4567_89AB_CDEF, 4'h5, 0, 0, "basic");
        run_header(60'h0FF_0000_0000_0010, 4'hC, 3, 2, "stall");
        test_wrap();
        run_header(60'h000_0000_0000_0000, 4'hF, 1, 0, "zero");
        run_header(60'h800_0000_0000_0001, 4'h0, 0, 4, "msb");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule